// File: doc/BRIEF.md
# Banked Shared Memory Arbiter

This block is the on-chip scratch memory that the threads of one group share. The storage is split into 32-bit banks, and consecutive words sit in consecutive banks. A request carries one slot per lane: an active bit, a write enable, a byte address and write data. There are 16 or 32 lanes. The arbiter sorts the active lanes by bank. In each cycle every bank serves one word, so lanes that land in distinct banks finish together. Lanes that hit one bank at different words are spread over successive cycles. Lanes that name the same word are served together in one access, and a read of that word is returned to each of them.

After a request is accepted, the block stays busy until every active lane has been served. It then raises a one-cycle done pulse. At that point the per-lane read data is valid, and a count shows how many serving cycles the request took. That count equals the largest number of distinct words that the request maps onto any one bank. A request that arrives while the block is busy is dropped. The caller waits for done before it presents the next request.

Top module: `shmem_bank_arb`

## Requirements
- R1: The word address of a lane is its byte address shifted right by two, so byte-address bits [1:0] have no effect. The bank is the word address modulo BANKS, which is the low log2(BANKS) bits of the word address.
- R2: A request whose active lanes each use a different bank, or share words only, is served in one cycle, and `cycles_used` reads 1 at done.
- R3: Active lanes that map to one bank at different words are served one word per cycle. `cycles_used` equals the largest count of distinct words in any single bank.
- R4: Active lanes that read the same word are served in the same cycle, and each of them returns that word's value. They add one cycle, not one cycle per lane.
- R5: When several active lanes write the same word in one request, the word afterwards holds the data of the highest-indexed of those lanes.
- R6: A read and a write of the same word in one request are served in the same cycle. The read returns the value the word held before that request.
- R7: Inactive lanes write nothing, do not count toward `cycles_used`, and return zero read data.
- R8: At done, `lane_rdata` holds the read value for every active reading lane and zero for writing lanes. The values stay stable until the next request is accepted.
- R9: `req_valid` has no effect while `busy` is high. The request in flight completes with its own count, and the memory is left untouched by the dropped request.
- R10: An accepted request with no active lane raises done on the next cycle with `cycles_used` of 0, and `busy` stays low.
- R11: After reset, `busy` and `done` are low and `cycles_used` and `lane_rdata` are zero.
- R12: `busy` is high from the cycle after acceptance for exactly `cycles_used` cycles. `done` is a single-cycle pulse in the first cycle with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| lane_active | input | LANES | Per-lane participation bit |
| lane_we | input | LANES | Per-lane write enable |
| lane_addr | input | LANES*ADDR_W | Per-lane byte address, lane n at bits [n*ADDR_W +: ADDR_W] |
| lane_wdata | input | LANES*DATA_W | Per-lane write data, lane n at bits [n*DATA_W +: DATA_W] |
| busy | output | 1 | Request being serialized |
| done | output | 1 | One-cycle completion pulse |
| lane_rdata | output | LANES*DATA_W | Per-lane read data, lane n at bits [n*DATA_W +: DATA_W] |
| cycles_used | output | $clog2(LANES+1) | Serving cycles taken by the last request |

## Verification
The properties assume that `req_valid` may be asserted at any time and that it is dropped silently while the block is busy. They also assume that the latched lane state changes only at acceptance. The progress property relies on each serving cycle retiring at least one active lane. The bench keeps every request inside the addressed word range. It reads a word only after writing it, so each expected value is defined. It pulses `req_valid` for a single cycle, except in the one scenario that deliberately asserts it during a busy period.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
   typedef enum logic {
      ARB_IDLE  = 1'b0,
      ARB_SERVE = 1'b1
   } arb_state_e;

   function automatic int unsigned cnt_width(input int unsigned lanes);
      return $clog2(lanes + 1);
   endfunction
endpackage

// File: rtl/shmem_bank_sel.sv
module shmem_bank_sel #(
   parameter int LANES   = 32,
   parameter int WORD_W  = 10,
   parameter int BANK_W  = 5,
   parameter int DATA_W  = 32,
   parameter int BANK_ID = 0
) (
   input  logic [LANES-1:0]        pend_i,
   input  logic [LANES-1:0]        we_i,
   input  logic [LANES*WORD_W-1:0] word_i,
   input  logic [LANES*DATA_W-1:0] wdata_i,
   output logic [LANES-1:0]        served_o,
   output logic [WORD_W-BANK_W-1:0] row_o,
   output logic                    wr_en_o,
   output logic [DATA_W-1:0]       wr_data_o
);
   localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

   logic [LANES-1:0]  hit;
   logic [WORD_W-1:0] lead_word;
   logic              found;

   always_comb begin
      found     = 1'b0;
      lead_word = '0;
      for (int l = 0; l < LANES; l++) begin
         hit[l] = pend_i[l] && (word_i[l*WORD_W +: BANK_W] == MY_BANK);
         if (hit[l] && !found) begin
            found     = 1'b1;
            lead_word = word_i[l*WORD_W +: WORD_W];
         end
      end
      for (int l = 0; l < LANES; l++) begin
         served_o[l] = hit[l] && (word_i[l*WORD_W +: WORD_W] == lead_word);
      end
      wr_en_o   = 1'b0;
      wr_data_o = '0;
      for (int l = 0; l < LANES; l++) begin
         if (served_o[l] && we_i[l]) begin
            wr_en_o   = 1'b1;
            wr_data_o = wdata_i[l*DATA_W +: DATA_W];
         end
      end
      row_o = lead_word[WORD_W-1:BANK_W];
   end
endmodule

// File: rtl/shmem_bank_ram.sv
module shmem_bank_ram #(
   parameter int ROWS   = 32,
   parameter int DATA_W = 32,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic [ROW_W-1:0]  row_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [DATA_W-1:0] cells [ROWS];

   assign rd_data_o = cells[row_i];

   always_ff @(posedge clk) begin
      if (wr_en_i) cells[row_i] <= wr_data_i;
   end
endmodule

// File: rtl/shmem_bank_arb.sv
module shmem_bank_arb
   import shmem_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int BANKS  = 32,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [LANES-1:0]        lane_active,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*ADDR_W-1:0] lane_addr,
   input  logic [LANES*DATA_W-1:0] lane_wdata,
   output logic                    busy,
   output logic                    done,
   output logic [LANES*DATA_W-1:0] lane_rdata,
   output logic [CNT_W-1:0]        cycles_used
);
   localparam int BANK_W = $clog2(BANKS);
   localparam int WORD_W = ADDR_W - 2;
   localparam int ROW_W  = WORD_W - BANK_W;
   localparam int ROWS   = 1 << ROW_W;

   if (BANKS != 16 && BANKS != 32) begin : g_bad_banks
      $error("BANKS must be 16 or 32");
   end
   if (LANES != 16 && LANES != 32) begin : g_bad_lanes
      $error("LANES must be 16 or 32");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("DATA_W must be 32");
   end
   if (ROW_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the bank count");
   end

   arb_state_e                state_q;
   logic [LANES-1:0]          act_q, we_q, served_all;
   logic [LANES*WORD_W-1:0]   word_q, word_in;
   logic [LANES*DATA_W-1:0]   wdata_q, rdata_q;
   logic [CNT_W-1:0]          cnt_q, cycles_q;
   logic                      done_q;
   logic [LANES-1:0]          remain;

   logic [LANES-1:0]          served_b  [BANKS];
   logic [ROW_W-1:0]          row_b     [BANKS];
   logic                      wr_en_b   [BANKS];
   logic [DATA_W-1:0]         wr_data_b [BANKS];
   logic [DATA_W-1:0]         rd_b      [BANKS];

   for (genvar l = 0; l < LANES; l++) begin : g_word
      assign word_in[l*WORD_W +: WORD_W] = lane_addr[l*ADDR_W + 2 +: WORD_W];
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic bank_wr;
      shmem_bank_sel #(
         .LANES(LANES), .WORD_W(WORD_W), .BANK_W(BANK_W),
         .DATA_W(DATA_W), .BANK_ID(b)
      ) sel_i (
         .pend_i   (act_q),
         .we_i     (we_q),
         .word_i   (word_q),
         .wdata_i  (wdata_q),
         .served_o (served_b[b]),
         .row_o    (row_b[b]),
         .wr_en_o  (wr_en_b[b]),
         .wr_data_o(wr_data_b[b])
      );
      assign bank_wr = wr_en_b[b] && (state_q == ARB_SERVE);
      shmem_bank_ram #(.ROWS(ROWS), .DATA_W(DATA_W)) ram_i (
         .clk      (clk),
         .row_i    (row_b[b]),
         .wr_en_i  (bank_wr),
         .wr_data_i(wr_data_b[b]),
         .rd_data_o(rd_b[b])
      );
   end

   always_comb begin
      served_all = '0;
      for (int b = 0; b < BANKS; b++) served_all |= served_b[b];
   end
   assign remain = act_q & ~served_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ARB_IDLE;
         act_q    <= '0;
         we_q     <= '0;
         word_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         cnt_q    <= '0;
         cycles_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ARB_IDLE: begin
               if (req_valid) begin
                  act_q   <= lane_active;
                  we_q    <= lane_we;
                  word_q  <= word_in;
                  wdata_q <= lane_wdata;
                  rdata_q <= '0;
                  cnt_q   <= '0;
                  if (lane_active == '0) begin
                     done_q   <= 1'b1;
                     cycles_q <= '0;
                  end else begin
                     state_q <= ARB_SERVE;
                  end
               end
            end
            ARB_SERVE: begin
               act_q <= remain;
               cnt_q <= cnt_q + 1'b1;
               for (int l = 0; l < LANES; l++) begin
                  if (served_all[l] && !we_q[l])
                     rdata_q[l*DATA_W +: DATA_W] <= rd_b[word_q[l*WORD_W +: BANK_W]];
               end
               if (remain == '0) begin
                  state_q  <= ARB_IDLE;
                  done_q   <= 1'b1;
                  cycles_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign busy        = (state_q == ARB_SERVE);
   assign done        = done_q;
   assign lane_rdata  = rdata_q;
   assign cycles_used = cycles_q;

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   serve_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((act_q & ~$past(act_q)) == '0) && (act_q != $past(act_q)));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(we_q) && $stable(word_q) && $stable(wdata_q));

   // R3
   cycle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cycles_used <= CNT_W'(LANES)) && (cycles_used != '0 || act_q == '0));

   // R10
   empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && lane_active == '0) |=> done && !busy && cycles_used == '0);

   // R12
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && lane_active != '0) |=> busy && !done);
endmodule

// File: tb/shmem_bank_arb_tb.sv
module shmem_bank_arb_tb_top;
   localparam int LANES  = 32;
   localparam int BANKS  = 32;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int CNT_W  = $clog2(LANES + 1);
   localparam int WORDS  = 1 << (ADDR_W - 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [LANES-1:0]        act_v = '0, we_v = '0;
   logic [LANES*ADDR_W-1:0] addr_v = '0;
   logic [LANES*DATA_W-1:0] wdata_v = '0;
   logic                    busy, done;
   logic [LANES*DATA_W-1:0] rdata;
   logic [CNT_W-1:0]        cycles_used;

   int checks = 0;
   int errors = 0;
   logic [DATA_W-1:0] model [WORDS];

   always #10ns clk = ~clk;

   shmem_bank_arb #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .lane_active(act_v), .lane_we(we_v), .lane_addr(addr_v), .lane_wdata(wdata_v),
      .busy(busy), .done(done), .lane_rdata(rdata), .cycles_used(cycles_used)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic clear_lanes();
      act_v = '0; we_v = '0; addr_v = '0; wdata_v = '0;
   endtask

   task automatic set_lane(input int l, input bit we, input int word, input int off,
                           input logic [DATA_W-1:0] d);
      act_v[l] = 1'b1;
      we_v[l]  = we;
      addr_v[l*ADDR_W +: ADDR_W] = ADDR_W'(word * 4 + off);
      wdata_v[l*DATA_W +: DATA_W] = d;
   endtask

   function automatic int word_of(input int l);
      return int'(addr_v[l*ADDR_W + 2 +: ADDR_W-2]);
   endfunction

   // issue the current lane set, wait for done, compare everything
   task automatic run_req(input string tag);
      logic [LANES*DATA_W-1:0] exp_rd;
      int exp_n, j, lat;
      bit mis;
      exp_rd = '0;
      exp_n  = 0;
      for (int l = 0; l < LANES; l++)
         if (act_v[l] && !we_v[l]) exp_rd[l*DATA_W +: DATA_W] = model[word_of(l)];
      for (int b = 0; b < BANKS; b++) begin
         int cnt = 0;
         for (int i = 0; i < LANES; i++) begin
            bit dup = 0;
            if (!act_v[i] || (word_of(i) % BANKS) != b) continue;
            for (int k = 0; k < i; k++)
               if (act_v[k] && word_of(k) == word_of(i)) dup = 1;
            if (!dup) cnt++;
         end
         if (cnt > exp_n) exp_n = cnt;
      end
      @(negedge clk); req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
      j = 0; mis = 0;
      while (!done && j <= LANES + 2) begin
         if (!busy) mis = 1;
         @(negedge clk); j++;
      end
      lat = j;
      chk(!mis, tag, "busy dropped before done", 64'(mis), 64'd0);
      chk(done && !busy, tag, "done pulse", {busy, done}, 64'd1);
      chk(lat == exp_n, tag, "done latency", 64'(lat), 64'(exp_n));
      chk(cycles_used == CNT_W'(exp_n), tag, "cycles_used", 64'(cycles_used), 64'(exp_n));
      mis = 0;
      for (int l = 0; l < LANES; l++)
         if (rdata[l*DATA_W +: DATA_W] !== exp_rd[l*DATA_W +: DATA_W]) begin
            if (!mis) $display("FAIL %s lane %0d rdata: actual %0h expected %0h", tag, l,
                               rdata[l*DATA_W +: DATA_W], exp_rd[l*DATA_W +: DATA_W]);
            mis = 1;
         end
      checks++;
      if (mis) errors++;
      for (int l = 0; l < LANES; l++)
         if (act_v[l] && we_v[l]) model[word_of(l)] = wdata_v[l*DATA_W +: DATA_W];
      @(negedge clk);
      chk(!done, tag, "done single pulse", 64'(done), 64'd0);
   endtask

   task automatic t_reset();
      chk(!busy && !done, "R11", "busy/done at reset", {busy, done}, 64'd0);
      chk(cycles_used == '0, "R11", "cycles_used at reset", 64'(cycles_used), 64'd0);
      chk(rdata == '0, "R11", "rdata at reset", rdata[63:0], 64'd0);
   endtask

   task automatic t_fill();
      // R2: word w written by lane w%32; four conflict-free rounds
      for (int r = 0; r < WORDS / LANES; r++) begin
         clear_lanes();
         for (int l = 0; l < LANES; l++) set_lane(l, 1, r * LANES + l, 0, 32'hA500_0000 + r * LANES + l);
         run_req("R2");
         if (r == 3) break;
      end
   endtask

   task automatic t_offsets();
      // R1: nonzero byte offsets select the same word
      clear_lanes();
      for (int l = 0; l < LANES; l++) set_lane(l, 0, (l * 7) % LANES, l % 4, '0);
      run_req("R1");
   endtask

   task automatic t_stride2();
      // R3: two distinct words per even bank
      clear_lanes();
      for (int l = 0; l < LANES; l++) set_lane(l, 0, 2 * l, 0, '0);
      run_req("R3");
   endtask

   task automatic t_stride32();
      // R3: every lane in bank 0, all words distinct
      clear_lanes();
      for (int l = 0; l < LANES; l++) set_lane(l, 1, 32 * l, 0, 32'h5A00_0000 + l);
      run_req("R3");
      clear_lanes();
      for (int l = 0; l < LANES; l++) set_lane(l, 0, 32 * (LANES - 1 - l), 0, '0);
      run_req("R3");
   endtask

   task automatic t_broadcast();
      // R4: all lanes on one word, then two words in one bank
      clear_lanes();
      for (int l = 0; l < LANES; l++) set_lane(l, 0, 5, l % 4, '0);
      run_req("R4");
      clear_lanes();
      for (int l = 0; l < LANES; l++) set_lane(l, 0, (l % 2 == 0) ? 5 : 37, 0, '0);
      run_req("R4");
   endtask

   task automatic t_multi_write();
      // R5: lanes 3, 9 and 20 write word 7; lane 20 must win
      clear_lanes();
      set_lane(3, 1, 7, 0, 32'h0000_0003);
      set_lane(20, 1, 7, 0, 32'h0000_0020);
      set_lane(9, 1, 7, 0, 32'h0000_0009);
      run_req("R5");
      clear_lanes();
      set_lane(0, 0, 7, 0, '0);
      run_req("R5");
      chk(rdata[DATA_W-1:0] == 32'h20, "R5", "winning writer", 64'(rdata[DATA_W-1:0]), 64'h20);
   endtask

   task automatic t_read_write();
      // R6, R8: read of a word written in the same request sees the old value
      logic [DATA_W-1:0] old_v;
      old_v = model[8];
      clear_lanes();
      set_lane(0, 1, 8, 0, 32'hFEED_0008);
      set_lane(1, 0, 8, 0, '0);
      run_req("R6");
      chk(rdata[DATA_W +: DATA_W] == old_v, "R6", "read before write", 64'(rdata[DATA_W +: DATA_W]), 64'(old_v));
      chk(rdata[DATA_W-1:0] == '0, "R8", "writer rdata zero", 64'(rdata[DATA_W-1:0]), 64'd0);
      repeat (3) @(negedge clk);
      chk(rdata[DATA_W +: DATA_W] == old_v, "R8", "rdata held", 64'(rdata[DATA_W +: DATA_W]), 64'(old_v));
   endtask

   task automatic t_inactive();
      // R7: inactive writer to word 40 must have no effect
      logic [DATA_W-1:0] keep;
      keep = model[40];
      clear_lanes();
      set_lane(2, 0, 40, 0, '0);
      set_lane(4, 1, 72, 0, 32'h1111_2222);
      set_lane(6, 1, 40, 0, 32'hBAD0_BAD0);
      act_v[6] = 1'b0;
      run_req("R7");
      clear_lanes();
      set_lane(0, 0, 40, 0, '0);
      run_req("R7");
      chk(rdata[DATA_W-1:0] == keep, "R7", "inactive write ignored", 64'(rdata[DATA_W-1:0]), 64'(keep));
   endtask

   task automatic t_busy_ignore();
      // R9: a write strobed mid-request is dropped
      logic [DATA_W-1:0] keep;
      int j;
      keep = model[0];
      clear_lanes();
      for (int l = 0; l < LANES; l++) set_lane(l, 0, 32 * l, 0, '0);
      @(negedge clk); req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
      j = 0;
      while (!done && j <= LANES + 2) begin
         if (j == 3) begin
            clear_lanes();
            set_lane(0, 1, 0, 0, 32'hDEAD_BEEF);
            req_valid = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk); j++;
      end
      req_valid = 1'b0;
      chk(cycles_used == CNT_W'(LANES), "R9", "in-flight count", 64'(cycles_used), 64'(LANES));
      clear_lanes();
      set_lane(0, 0, 0, 0, '0);
      run_req("R9");
      chk(rdata[DATA_W-1:0] == keep, "R9", "dropped write", 64'(rdata[DATA_W-1:0]), 64'(keep));
   endtask

   task automatic t_empty();
      // R10
      clear_lanes();
      run_req("R10");
   endtask

   initial begin
      #100ms;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fill();
      t_offsets();
      t_stride2();
      t_stride32();
      t_broadcast();
      t_multi_write();
      t_read_write();
      t_inactive();
      t_busy_ignore();
      t_empty();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule